// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block receives configuration words from a host over a three-wire serial link made of a serial clock, a data line and a latch strobe. It stores them in a small register file whose contents drive the rest of the chip directly. The three wires are asynchronous to the system clock. Each one passes through a synchroniser, and all edge detection happens in the system clock domain.

Bits enter a 32-bit shift register, most significant bit first. One bit is taken on every rising edge of the serial clock. When the latch strobe rises, the last 32 bits captured form one word. The low nibble of the word selects a register, and the upper 28 bits become that register's new contents. Address 15 is the calibration register. Every accepted write to it raises a one-cycle calibration-start strobe, even when the new value equals the stored one. A parameter mask defines which addresses have storage, and writes to any other address are dropped.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, all sixteen register outputs read zero and `cal_start_o` is low.
- R2: Data is taken MSB first, one bit on each rising edge of `ser_clk_i`, so the first bit shifted ends up in word bit 31.
- R3: On a rising edge of `ser_le_i`, word bits [31:4] are written into the register selected by word bits [3:0], and all other registers keep their value.
- R4: Shifting without a rising edge of `ser_le_i` changes no register output.
- R5: Each write to address 15 produces exactly one `cal_start_o` pulse of one system clock cycle, including a write of an unchanged value.
- R6: The pulse on `cal_start_o` is issued only once register 15 already shows the written value.
- R7: A write to any address other than 15 produces no pulse on `cal_start_o`.
- R8: When more or fewer than 32 bits are shifted between strobes, the word used is the last 32 bits captured since reset.
- R9: A write to an address with no storage (address 14 by default) leaves every register output unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous, idles low |
| ser_data_i | input | 1 | Serial data, asynchronous, idles low |
| ser_le_i | input | 1 | Latch strobe, asynchronous, idles low |
| regs_o | output | 448 | Register contents, register k at bits [28k+27:28k] |
| cal_start_o | output | 1 | One-cycle calibration-start strobe |

## Verification
The bench goes after bit order and field placement with payloads that have only the top or only the bottom bit set. A reversed shift or a swapped field would place such a bit in the wrong register or the wrong position. It rewrites the calibration register with an unchanged value, which would produce no strobe in a design that compares old and new values. It also measures the strobe width and samples register 15 while the strobe is high, to catch a strobe that stretches or arrives before the update. Further cases cover overlong and short shifts, shifting without a latch, and a write to the address with no storage. A design that kept the first 32 bits, updated registers while bits were still shifting, or decoded the missing address would each show a register value that the bench does not expect.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int unsigned CFG_WORD_W   = 32;
  localparam int unsigned CFG_ADDR_W   = 4;
  localparam int unsigned CFG_SYNC_LEN = 2;
  localparam int unsigned CFG_CAL_ADDR = 15;
  localparam logic [15:0] CFG_IMPL_MASK = 16'hBFFF;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_s,
  input  logic              bdat_s,
  input  logic              strobe_s,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_word
);
  logic              bclk_q, strobe_q;
  logic [WORD_W-1:0] shreg;
  logic              bclk_rise, strobe_rise;

  assign bclk_rise   = bclk_s & ~bclk_q;
  assign strobe_rise = strobe_s & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      shreg    <= '0;
      wr_valid <= 1'b0;
      wr_word  <= '0;
    end else begin
      bclk_q   <= bclk_s;
      strobe_q <= strobe_s;
      if (bclk_rise)   shreg   <= {shreg[WORD_W-2:0], bdat_s};
      wr_valid <= strobe_rise;
      if (strobe_rise) wr_word <= shreg;
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CAL_ADDR  = 15,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1,
  localparam int unsigned DATA_W   = WORD_W - ADDR_W,
  localparam int unsigned NREGS    = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic [WORD_W-1:0]       wr_word,
  output logic [NREGS*DATA_W-1:0] regs_flat,
  output logic                    cal_o
);
  logic [DATA_W-1:0] mem [NREGS];
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              cal_arm;

  assign addr = wr_word[ADDR_W-1:0];
  assign data = wr_word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      cal_arm <= 1'b0;
      cal_o   <= 1'b0;
    end else begin
      cal_arm <= 1'b0;
      if (wr_valid && IMPL_MASK[addr]) begin
        mem[addr] <= data;
        cal_arm   <= (addr == ADDR_W'(CAL_ADDR));
      end
      cal_o <= cal_arm;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_serial_pkg::*;
#(
  parameter int unsigned WORD_W   = CFG_WORD_W,
  parameter int unsigned ADDR_W   = CFG_ADDR_W,
  parameter int unsigned SYNC_LEN = CFG_SYNC_LEN,
  parameter int unsigned CAL_ADDR = CFG_CAL_ADDR,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = CFG_IMPL_MASK,
  localparam int unsigned DATA_W  = WORD_W - ADDR_W,
  localparam int unsigned NREGS   = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ser_clk_i,
  input  logic                    ser_data_i,
  input  logic                    ser_le_i,
  output logic [NREGS*DATA_W-1:0] regs_o,
  output logic                    cal_start_o
);
  logic [2:0]        pins_s;
  logic              wr_valid;
  logic [WORD_W-1:0] wr_word;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ser_le_i, ser_data_i, ser_clk_i}),
    .sync_o  (pins_s)
  );

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bclk_s   (pins_s[0]),
    .bdat_s   (pins_s[1]),
    .strobe_s (pins_s[2]),
    .wr_valid (wr_valid),
    .wr_word  (wr_word)
  );

  cfg_regfile #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CAL_ADDR(CAL_ADDR), .IMPL_MASK(IMPL_MASK)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_word   (wr_word),
    .regs_flat (regs_o),
    .cal_o     (cal_start_o)
  );
endmodule

// File: rtl/cfg_serial_checker.sv
module cfg_serial_checker #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CAL_ADDR = 15,
  parameter logic [(1<<ADDR_W)-1:0] IMPL_MASK = '1,
  localparam int unsigned DATA_W  = WORD_W - ADDR_W,
  localparam int unsigned NREGS   = 1 << ADDR_W
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_valid,
  input logic [WORD_W-1:0]       wr_word,
  input logic [NREGS*DATA_W-1:0] regs_o,
  input logic                    cal_start_o
);
  logic [ADDR_W-1:0] w_addr;
  assign w_addr = wr_word[ADDR_W-1:0];

  assert_reg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_valid) |-> $stable(regs_o));

  assert_cal_single_R5: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |=> !cal_start_o);

  assert_cal_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |-> ($past(wr_valid, 2) && $past(w_addr, 2) == ADDR_W'(CAL_ADDR)
                     && regs_o[CAL_ADDR*DATA_W +: DATA_W] == $past(wr_word[WORD_W-1:ADDR_W], 2)));

  assert_no_cal_other_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && w_addr != ADDR_W'(CAL_ADDR)) |=> ##1 !cal_start_o);

  assert_unimpl_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !IMPL_MASK[w_addr]) |=> $stable(regs_o));
endmodule

bind cfg_serial_slave cfg_serial_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CAL_ADDR(CAL_ADDR), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_word     (wr_word),
  .regs_o      (regs_o),
  .cal_start_o (cal_start_o)
);

// File: tb/tb_cfg_serial_slave.sv
module tb_cfg_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_le_i = 1'b0;
  logic [16*28-1:0] regs_o;
  logic cal_start_o;

  int n_checks = 0, n_fails = 0;
  int cal_cnt = 0, cal_run = 0, cal_max_run = 0;
  logic [27:0] cal_val = '0;
  logic [27:0] model_regs [16];
  logic [31:0] model_sh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i),
    .ser_le_i(ser_le_i), .regs_o(regs_o), .cal_start_o(cal_start_o)
  );

  always @(negedge clk) begin
    if (!rst && cal_start_o) begin
      cal_cnt++;
      cal_run++;
      cal_val = regs_o[15*28 +: 28];
      if (cal_run > cal_max_run) cal_max_run = cal_run;
    end else begin
      cal_run = 0;
    end
  end

  function automatic logic [27:0] reg_at(input int a);
    return regs_o[a*28 +: 28];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 16; a++) check(tag, 32'(reg_at(a)), 32'(model_regs[a]));
  endtask

  task automatic shift_bit(input logic b);
    ser_data_i = b;
    repeat (PHASE) @(negedge clk);
    ser_clk_i = 1'b1;
    model_sh = {model_sh[30:0], b};
    repeat (PHASE) @(negedge clk);
    ser_clk_i = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    ser_data_i = 1'b0;
  endtask

  task automatic latch();
    ser_le_i = 1'b1;
    repeat (PHASE) @(negedge clk);
    ser_le_i = 1'b0;
    repeat (12) @(negedge clk);
    if (model_sh[3:0] != 4'd14) model_regs[model_sh[3:0]] = model_sh[31:4];
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [27:0] v);
    send_bits({32'h0, v, a}, 32);
    latch();
  endtask

  task automatic t_reset();
    check_all("R1 reset value");
    check("R1 cal low", 32'(cal_start_o), 32'd0);
    check("R1 no pulse", cal_cnt, 0);
  endtask

  task automatic t_basic();
    write_reg(4'd3, 28'hABCDEF1);
    check("R2 reg3", 32'(reg_at(3)), 32'h0ABCDEF1);
    check_all("R3 decode");
  endtask

  task automatic t_patterns();
    int c0 = cal_cnt;
    write_reg(4'd0, 28'h0000001);
    write_reg(4'd7, 28'h8000000);
    write_reg(4'd13, 28'h5A5A5A5);
    check("R2 lsb", 32'(reg_at(0)), 32'h1);
    check("R2 msb", 32'(reg_at(7)), 32'h08000000);
    check_all("R3 patterns");
    check("R7 no pulse", cal_cnt, c0);
  endtask

  task automatic t_no_latch();
    send_bits({32'h0, 28'h1234567, 4'd5}, 32);
    repeat (20) @(negedge clk);
    check("R4 before latch", 32'(reg_at(5)), 32'h0);
    check_all("R4 hold");
    latch();
    check("R4 after latch", 32'(reg_at(5)), 32'h01234567);
  endtask

  task automatic t_cal();
    int c0 = cal_cnt;
    write_reg(4'd15, 28'h0F0F0F0);
    check("R5 one pulse", cal_cnt, c0 + 1);
    check("R6 value at pulse", 32'(cal_val), 32'h00F0F0F0);
    write_reg(4'd15, 28'h0F0F0F0);
    check("R5 same value pulse", cal_cnt, c0 + 2);
    check("R5 width", cal_max_run, 1);
    write_reg(4'd2, 28'h7777777);
    check("R7 other addr", cal_cnt, c0 + 2);
  endtask

  task automatic t_lengths();
    send_bits({24'h0, 8'hFF, 28'h2468ACE, 4'd9}, 40);
    latch();
    check("R8 long", 32'(reg_at(9)), 32'h02468ACE);
    send_bits(64'h61, 8);
    latch();
    check_all("R8 short");
  endtask

  task automatic t_unimpl();
    int c0 = cal_cnt;
    write_reg(4'd14, 28'hFFFFFFF);
    check("R9 reg14", 32'(reg_at(14)), 32'h0);
    check_all("R9 unchanged");
    check("R9 no pulse", cal_cnt, c0);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) model_regs[a] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_patterns();
    t_no_latch();
    t_cal();
    t_lengths();
    t_unimpl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule